// File: doc/BRIEF.md
# Per-Instruction Stride Prefetch Predictor

This block watches the stream of memory accesses issued by load and store instructions. It learns, separately for each instruction, whether that instruction walks memory with a constant step. Every access carries the instruction's program counter and the effective address it touched. The block keeps a small direct-mapped table keyed by the program counter. Each slot stores a tag, the last address the instruction used, the last step seen and a confidence state with four values: initial, transient, steady and no-prediction.

Once an instruction's step has been confirmed, each further access produces a prefetch request for the current address plus the step. A confirmed step is two successive address differences that agree. The request appears on a registered output one cycle after the access is accepted.

Both the access input and the prefetch output use valid/ready handshakes. The output holds a single request. While that request is stalled by `pf_ready` low, `acc_ready` is low and no access is taken. Every accepted access rewrites its table slot, so the slot always holds an up-to-date view of that instruction.

Top module: `stride_prefetch_table`

## Requirements
- R1: After reset `pf_valid` is 0, `acc_ready` is 1, and every table slot is empty, so the first access of any program counter produces no prefetch.
- R2: The slot index is `acc_pc[IDX_W+1:2]` (bits 5:2 by default). The tag is `acc_pc[PC_W-1:IDX_W+2]`. Bits 1:0 of the program counter are ignored. An access whose tag differs from the stored tag evicts that slot.
- R3: A tag miss or an empty slot loads the slot with state initial, step 0 and the current address, and produces no prefetch.
- R4: On a hit in state initial, a difference equal to the stored step moves the slot to steady. Any other difference moves it to transient and stores the difference as the new step.
- R5: On a hit in state transient, a matching difference moves the slot to steady. A mismatch moves it to no-prediction and stores the difference as the new step.
- R6: On a hit in state steady, a matching difference keeps steady. A mismatch returns the slot to initial and keeps the stored step.
- R7: On a hit in state no-prediction, a matching difference moves the slot to transient. A mismatch stays in no-prediction and stores the difference as the new step.
- R8: When the updated state is steady and the step is nonzero, `pf_valid` rises on the clock edge that accepts the access. At that point `pf_addr` equals the access address plus the step, computed modulo 2^ADDR_W, so negative steps work.
- R9: A step of zero never produces a prefetch, even in state steady.
- R10: `acc_ready` equals `!pf_valid || pf_ready`. While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` and `pf_addr` hold their values.
- R11: Every accepted access stores its own address as the slot's previous address, whatever the state change.
- R12: An access offered while `acc_ready` is 0 is ignored and changes no slot. `pf_valid` only rises after an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_pc | input | PC_W | Program counter of the load/store |
| acc_addr | input | ADDR_W | Effective address of the access |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer takes the prefetch request |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The embedded assertions check, on every cycle, the output handshake rules: a stalled request is held stable and the input is refused while it is stalled. They also check that a miss, a zero difference or an absence of accepted access never leaves a request behind, and that a confirmed step always issues one. Only the bench's scenarios can show the full confidence walk through all four states. They also show the step being kept or replaced on each mismatch, aliasing of the low program-counter bits, eviction by a foreign tag, independence of interleaved instructions, negative steps, and that a refused access truly left its slot untouched.

// File: rtl/stp_pkg.sv
package stp_pkg;

  typedef enum logic [1:0] {
    CONF_INIT   = 2'd0,
    CONF_TRANS  = 2'd1,
    CONF_STEADY = 2'd2,
    CONF_NOPRED = 2'd3
  } conf_e;

  // Next confidence state for a hit, given whether the new difference matched.
  function automatic conf_e conf_next(input conf_e cur, input logic match);
    unique case (cur)
      CONF_INIT:   conf_next = match ? CONF_STEADY : CONF_TRANS;
      CONF_TRANS:  conf_next = match ? CONF_STEADY : CONF_NOPRED;
      CONF_STEADY: conf_next = match ? CONF_STEADY : CONF_INIT;
      default:     conf_next = match ? CONF_TRANS  : CONF_NOPRED;
    endcase
  endfunction

  // Whether a mismatch in this state replaces the stored step.
  function automatic logic conf_takes_step(input conf_e cur);
    conf_takes_step = (cur != CONF_STEADY);
  endfunction

endpackage

// File: rtl/stp_table.sv
module stp_table
  import stp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // read port (combinational)
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_prev,
  output logic [ADDR_W-1:0] rd_step,
  output conf_e             rd_conf,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_prev,
  input  logic [ADDR_W-1:0] wr_step,
  input  conf_e             wr_conf
);

  localparam int ENTRIES = 1 << IDX_W;

  logic              slot_vld  [ENTRIES];
  logic [TAG_W-1:0]  slot_tag  [ENTRIES];
  logic [ADDR_W-1:0] slot_prev [ENTRIES];
  logic [ADDR_W-1:0] slot_step [ENTRIES];
  conf_e             slot_conf [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[e]  <= 1'b0;
        slot_tag[e]  <= '0;
        slot_prev[e] <= '0;
        slot_step[e] <= '0;
        slot_conf[e] <= CONF_INIT;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        slot_vld[e]  <= 1'b1;
        slot_tag[e]  <= wr_tag;
        slot_prev[e] <= wr_prev;
        slot_step[e] <= wr_step;
        slot_conf[e] <= wr_conf;
      end
    end
  end

  always_comb begin
    rd_hit  = slot_vld[rd_idx] && (slot_tag[rd_idx] == rd_tag);
    rd_prev = slot_prev[rd_idx];
    rd_step = slot_step[rd_idx];
    rd_conf = slot_conf[rd_idx];
  end

endmodule

// File: rtl/stp_update.sv
module stp_update
  import stp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              hit,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] old_prev,
  input  logic [ADDR_W-1:0] old_step,
  input  conf_e             old_conf,
  output logic [ADDR_W-1:0] new_step,
  output conf_e             new_conf,
  output logic              issue,
  output logic [ADDR_W-1:0] issue_addr
);

  logic [ADDR_W-1:0] diff;
  logic              match;

  always_comb begin
    diff  = cur_addr - old_prev;
    match = (diff == old_step);
    if (!hit) begin
      new_step = '0;
      new_conf = CONF_INIT;
    end else begin
      new_conf = conf_next(old_conf, match);
      new_step = (!match && conf_takes_step(old_conf)) ? diff : old_step;
    end
    issue      = hit && (new_conf == CONF_STEADY) && (new_step != '0);
    issue_addr = cur_addr + new_step;
  end

endmodule

// File: rtl/stp_out.sv
module stp_out #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  output logic              acc_fire,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);

  assign acc_ready = !pf_valid || pf_ready;
  assign acc_fire  = acc_valid && acc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (acc_fire) begin
      pf_valid <= issue;
      if (issue) pf_addr <= issue_addr;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end

  // R10: a stalled request stays put
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  // R10: no access is taken while the request is stalled
  a_r10_refuse_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |-> !acc_ready);

  // R12: a request only appears after an accepted access
  a_r12_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_fire && !pf_valid) |=> !pf_valid);

endmodule

// File: rtl/stride_prefetch_table.sv
module stride_prefetch_table
  import stp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);

  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_W  = PC_W - TAG_LO;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              unused_pc_lo;
  logic              hit;
  logic [ADDR_W-1:0] old_prev, old_step, new_step, issue_addr;
  conf_e             old_conf, new_conf;
  logic              issue, acc_fire;

  assign idx          = acc_pc[TAG_LO-1:IDX_LO];
  assign tag          = acc_pc[PC_W-1:TAG_LO];
  assign unused_pc_lo = ^acc_pc[IDX_LO-1:0];

  stp_table #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (idx),
    .rd_tag  (tag),
    .rd_hit  (hit),
    .rd_prev (old_prev),
    .rd_step (old_step),
    .rd_conf (old_conf),
    .wr_en   (acc_fire),
    .wr_idx  (idx),
    .wr_tag  (tag),
    .wr_prev (acc_addr),
    .wr_step (new_step),
    .wr_conf (new_conf)
  );

  stp_update #(.ADDR_W(ADDR_W)) u_update (
    .hit        (hit),
    .cur_addr   (acc_addr),
    .old_prev   (old_prev),
    .old_step   (old_step),
    .old_conf   (old_conf),
    .new_step   (new_step),
    .new_conf   (new_conf),
    .issue      (issue),
    .issue_addr (issue_addr)
  );

  stp_out #(.ADDR_W(ADDR_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_fire   (acc_fire),
    .issue      (issue),
    .issue_addr (issue_addr),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr)
  );

  // R3: a miss never leaves a request behind
  a_r3_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !hit) |=> !pf_valid);

  // R9: a zero difference never yields a request
  a_r9_zero_step_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && hit && (acc_addr == old_prev)) |=> !pf_valid);

  // R8: a confirmed nonzero step in steady always issues
  a_r8_steady_issues: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && hit && (old_conf == CONF_STEADY) && (acc_addr != old_prev)
     && ((acc_addr - old_prev) == old_step))
    |=> (pf_valid && (pf_addr == $past(acc_addr + old_step))));

endmodule

// File: tb/tb_stride_prefetch_table.sv
module tb_stride_prefetch_table;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  stride_prefetch_table dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_pc(acc_pc), .acc_addr(acc_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  localparam int NV = 22;
  localparam logic [31:0] V_PC [NV] = '{
    32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'h1000,
    32'h1004, 32'h1004, 32'h1004, 32'h1004, 32'h1004, 32'h1004,
    32'h1000, 32'h1002, 32'h2000, 32'h1000,
    32'h1008, 32'h1008, 32'h1008,
    32'h100C, 32'h100C, 32'h100C};
  localparam logic [31:0] V_ADDR [NV] = '{
    50000, 50004, 50008, 50012, 50020, 50024,
    90000, 90400, 91200, 91300, 91400, 91500,
    50028, 50032, 70000, 50036,
    30000, 30000, 30000,
    1000, 992, 984};
  localparam logic V_PFV [NV] = '{
    0, 0, 1, 1, 0, 1,
    0, 0, 0, 0, 0, 1,
    1, 1, 0, 0,
    0, 0, 0,
    0, 0, 1};
  localparam logic [31:0] V_PFA [NV] = '{
    0, 0, 50012, 50016, 0, 50028,
    0, 0, 0, 0, 0, 91600,
    50032, 50036, 0, 0,
    0, 0, 0,
    0, 0, 976};
  localparam string V_REQ [NV] = '{
    "R3", "R4", "R8", "R6", "R6", "R4",
    "R3", "R5", "R5", "R7", "R7", "R5",
    "R8", "R2", "R2", "R2",
    "R3", "R9", "R9",
    "R3", "R4", "R8"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, accept at the rising edge, look at the next falling edge.
  task automatic access(input logic [31:0] pc, input logic [31:0] addr,
                        input logic expv, input logic [31:0] expa, input string req);
    acc_valid = 1'b1;
    acc_pc    = pc;
    acc_addr  = addr;
    @(negedge clk);
    acc_valid = 1'b0;
    check(req, 32'(pf_valid), 32'(expv));
    if (expv) check(req, pf_addr, expa);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 32'(pf_valid), 0);
    check("R1", 32'(acc_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(pf_valid), 0);

    // Table walk: R2..R9, R11 (steps 5-6 show prev updated on a mismatch)
    for (int i = 0; i < NV; i++)
      access(V_PC[i], V_ADDR[i], V_PFV[i], V_PFA[i], V_REQ[i]);

    // R10 / R12: back-pressure and a refused access
    access(32'h100C, 976, 1'b1, 968, "R8");
    pf_ready  = 1'b0;
    acc_valid = 1'b1;
    acc_pc    = 32'h100C;
    acc_addr  = 500;
    #1;
    check("R10", 32'(acc_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", 32'(pf_valid), 1);
      check("R10", pf_addr, 968);
    end
    acc_valid = 1'b0;
    pf_ready  = 1'b1;
    @(negedge clk);
    check("R12", 32'(pf_valid), 0);
    @(negedge clk);
    check("R12", 32'(pf_valid), 0);
    // R12 / R11: the refused address must not have reached the slot
    access(32'h100C, 968, 1'b1, 960, "R12");

    // R1: reset in mid-run empties the table
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 32'(pf_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    access(32'h100C, 960, 1'b0, 0, "R1");
    access(32'h100C, 952, 1'b0, 0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule